// File: doc/BRIEF.md
# Pipelined Digit-Serial Binary Field Multiplier

This block multiplies two elements of GF(2^m), both in polynomial basis, and reduces the product modulo an irreducible polynomial fixed when the block is elaborated. Addition in this field is a bitwise XOR, so no carries propagate anywhere. The multiplier operand is consumed one digit of D bits at a time, most significant digit first. Each digit is handled by its own processing cell. The cells form a one-directional chain of ceil(m/D) stages, and no cell feeds back to an earlier one.

Each cell computes acc·x^D + a·digit and reduces the result modulo the field polynomial. The D+1 contributions are summed with a balanced XOR tree, so the depth of a cell grows with log2(D) and not with D. An operand pair presented with the input strobe enters a capture register, passes through every cell and leaves through an output register. A new pair may be presented on every clock, and results leave in the order the pairs arrived. When m is not a multiple of D, the multiplier operand is padded with zeros at its top end.

Top module: `gf_dsmul`

## Requirements
- R1: For every accepted pair, `out_p` equals a·b mod P. For the defaults (M=163, D=4), P is x^163 + x^7 + x^6 + x^3 + 1. The low-order part of P is hex C9, with bit i being the coefficient of x^i.
- R2: A pair sampled with `in_valid` high at rising edge e appears with `out_valid` high right after rising edge e+N+1, where N = ceil(M/D). This is a latency of N+2 cycles, which is 43 for the defaults.
- R3: Pairs may be presented on consecutive cycles with no gap. Their results come out on consecutive cycles in the same order.
- R4: `out_valid` is high for exactly one cycle per accepted pair and never at any other time.
- R5: Multiplying by the element 1 returns the other operand unchanged. Multiplying by 0, on either side, returns 0.
- R6: Terms at degree m and above fold back into the field. The product x^162 · x gives hex C9, and x^162 · x^162 gives x^324 mod P.
- R7: With M=13, D=3 and P = x^13 + x^4 + x^3 + x + 1 (low part hex 1B), the operand is padded to 15 bits and every product is correct.
- R8: While `rst_n` is low, `out_valid` is low. A reset asserted with products in flight discards them, so none of them appears afterwards. Pairs are accepted again from the third rising edge after release.
- R9: The values on `in_a` and `in_b` in cycles where `in_valid` is low produce no result and do not change any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | M | Multiplicand, polynomial basis |
| in_b | input | M | Multiplier, polynomial basis, consumed digit by digit |
| out_valid | output | 1 | Result present this cycle (one-cycle pulse) |
| out_p | output | M | Reduced product a·b mod P |

## Verification
A wrong reduction or a wrong digit weight inside one cell corrupts the accumulator of every product that passes through that cell. The error then shows on `out_p` exactly N+2 cycles after the pair went in. A broken valid chain or clock enable shows as a missing, extra or late `out_valid` pulse within the same latency. A stuck or misaligned digit selection shows as a wrong value from the first product onward. The bench compares every result against a bit-serial shift-and-add model, both for the default field and for a small field whose width is not a multiple of the digit size.

// File: rtl/gf_dsmul_pkg.sv
package gf_dsmul_pkg;

  localparam int GF_M_DEF = 163;
  localparam int GF_D_DEF = 4;

  // low-order part of x^163 + x^7 + x^6 + x^3 + 1
  localparam logic [GF_M_DEF-1:0] GF_POLY_DEF = 163'hC9;

  function automatic int gf_digits(input int m, input int d);
    return (m + d - 1) / d;
  endfunction

endpackage

// File: rtl/gf_xor_tree.sv
// Balanced XOR reduction of NT words; depth is clog2(NT) gate levels.
module gf_xor_tree #(
  parameter int W  = 8,
  parameter int NT = 5
) (
  input  logic [NT-1:0][W-1:0] terms,
  output logic [W-1:0]         sum
);

  localparam int LV = (NT > 1) ? $clog2(NT) : 1;
  localparam int P2 = 1 << LV;

  logic [W-1:0] node [P2];

  always_comb begin
    for (int i = 0; i < P2; i++) begin
      node[i] = (i < NT) ? terms[i] : '0;
    end
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < (P2 >> (l + 1)); i++) begin
        node[i] = node[2*i] ^ node[2*i+1];
      end
    end
    sum = node[0];
  end

endmodule

// File: rtl/gf_dsmul_cell.sv
// One digit step: acc_o = (acc_i * x^D + a_i * digit) mod P
module gf_dsmul_cell #(
  parameter int            M    = 163,
  parameter int            D    = 4,
  parameter int            BW   = 164,
  parameter logic [M-1:0]  POLY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic [M-1:0]  acc_i,
  input  logic [M-1:0]  a_i,
  input  logic [BW-1:0] b_i,
  output logic          v_o,
  output logic [M-1:0]  acc_o,
  output logic [M-1:0]  a_o,
  output logic [BW-1:0] b_o
);

  localparam int NT = D + 1;

  logic [D-1:0]         dig;
  logic [NT-1:0][M-1:0] terms;
  logic [M-1:0]         acc_n;
  logic [BW-1:0]        b_n;

  function automatic logic [M-1:0] mulx(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  // next-state: partial terms
  always_comb begin
    logic [M-1:0] sh;
    logic [M-1:0] ac;
    dig = b_i[BW-1 -: D];
    ac  = acc_i;
    for (int k = 0; k < D; k++) begin
      ac = mulx(ac);
    end
    terms[0] = ac;
    sh = a_i;
    for (int j = 0; j < D; j++) begin
      terms[j+1] = dig[j] ? sh : '0;
      sh = mulx(sh);
    end
    b_n = b_i << D;
  end

  gf_xor_tree #(.W(M), .NT(NT)) u_tree (
    .terms (terms),
    .sum   (acc_n)
  );

  // registers, data gated by the valid strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      acc_o <= '0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        acc_o <= acc_n;
        a_o   <= a_i;
        b_o   <= b_n;
      end
    end
  end

  // R5: zero accumulator and zero digit leave a zero accumulator
  a_r5_zero_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && acc_i == '0 && b_i[BW-1 -: D] == '0) |=> (v_o && acc_o == '0));

  // R9: an idle cycle leaves the stage contents untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> ($stable(acc_o) && $stable(b_o) && $stable(a_o)));

endmodule

// File: rtl/gf_dsmul.sv
module gf_dsmul
  import gf_dsmul_pkg::*;
#(
  parameter int           M    = GF_M_DEF,
  parameter int           D    = GF_D_DEF,
  parameter logic [M-1:0] POLY = GF_POLY_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  output logic         out_valid,
  output logic [M-1:0] out_p
);

  localparam int N  = gf_digits(M, D);
  localparam int BW = N * D;
  localparam int CW = $clog2(N + 2) + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // capture stage
  logic          cap_v_q;
  logic [M-1:0]  cap_a_q;
  logic [BW-1:0] cap_b_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cap_v_q <= 1'b0;
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      cap_v_q <= in_valid;
      if (in_valid) begin
        cap_a_q <= in_a;
        cap_b_q <= BW'(in_b);
      end
    end
  end

  // systolic chain
  logic [N:0]    v_c;
  logic [M-1:0]  acc_c [N+1];
  logic [M-1:0]  a_c   [N+1];
  logic [BW-1:0] b_c   [N+1];

  assign v_c[0]   = cap_v_q;
  assign acc_c[0] = '0;
  assign a_c[0]   = cap_a_q;
  assign b_c[0]   = cap_b_q;

  for (genvar k = 0; k < N; k++) begin : g_cell
    gf_dsmul_cell #(.M(M), .D(D), .BW(BW), .POLY(POLY)) u_cell (
      .clk   (clk),
      .rst_n (srst_n),
      .v_i   (v_c[k]),
      .acc_i (acc_c[k]),
      .a_i   (a_c[k]),
      .b_i   (b_c[k]),
      .v_o   (v_c[k+1]),
      .acc_o (acc_c[k+1]),
      .a_o   (a_c[k+1]),
      .b_o   (b_c[k+1])
    );
  end

  // output stage
  logic         out_v_q;
  logic [M-1:0] out_p_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_v_q <= 1'b0;
      out_p_q <= '0;
    end else begin
      out_v_q <= v_c[N];
      if (v_c[N]) out_p_q <= acc_c[N];
    end
  end

  assign out_valid = out_v_q;
  assign out_p     = out_p_q;

  // occupancy of cells plus output register, for the checks below
  logic [CW-1:0] occ_q, occ_n;

  always_comb begin
    occ_n = occ_q + CW'(cap_v_q) - CW'(out_v_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) occ_q <= '0;
    else         occ_q <= occ_n;
  end

  // R4: no result without a pair in flight
  a_r4_no_orphan: assert property (@(posedge clk) disable iff (!srst_n)
    out_v_q |-> (occ_q != '0));

  // R3: in flight never exceeds the stage count
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!srst_n)
    occ_q <= CW'(N + 1));

  // R7: all padded digits consumed at the end of the chain
  a_r7_digits_consumed: assert property (@(posedge clk) disable iff (!srst_n)
    v_c[N] |-> (b_c[N] == '0));

  // R5: zero multiplicand gives zero product
  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!srst_n)
    (v_c[N] && a_c[N] == '0) |-> (acc_c[N] == '0));

endmodule

// File: tb/gf_dsmul_tb_top.sv
module gf_dsmul_tb_top;

  localparam int ML = 163;
  localparam int DL = 4;
  localparam int NL = (ML + DL - 1) / DL;
  localparam logic [162:0] PL = 163'hC9;

  localparam int MS = 13;
  localparam int DS = 3;
  localparam int NS = (MS + DS - 1) / DS;
  localparam logic [162:0] PS = 163'h1B;

  typedef struct {
    logic [162:0] exp;
    int           due;
    string        tag;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          vl, ovl;
  logic [ML-1:0] al, bl, pl;
  logic          vs, ovs;
  logic [MS-1:0] sa, sb, ps;

  int cyc;
  int n_chk;
  int n_fail;
  item_t q_l[$];
  item_t q_s[$];

  gf_dsmul dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (vl), .in_a (al), .in_b (bl),
    .out_valid (ovl), .out_p (pl)
  );

  gf_dsmul #(.M(MS), .D(DS), .POLY(13'h1B)) dut_s (
    .clk (clk), .rst_n (rst_n), .in_valid (vs), .in_a (sa), .in_b (sb),
    .out_valid (ovs), .out_p (ps)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bit-serial shift-and-add model
  function automatic logic [162:0] gf_ref(input logic [162:0] a, input logic [162:0] b,
                                          input int m, input logic [162:0] poly);
    logic [163:0] r;
    logic         top;
    r = '0;
    for (int i = m - 1; i >= 0; i--) begin
      top  = r[m-1];
      r    = r << 1;
      r[m] = 1'b0;
      if (top)  r = r ^ {1'b0, poly};
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[162:0];
  endfunction

  function automatic logic [162:0] rnd(input int m);
    logic [191:0] t;
    logic [162:0] mask;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    mask = '0;
    for (int i = 0; i < m; i++) mask[i] = 1'b1;
    return t[162:0] & mask;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [162:0] act,
                     input logic [162:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_l(input logic [162:0] a, input logic [162:0] b,
                        input logic [162:0] e, input string tag);
    item_t it;
    @(negedge clk);
    vl = 1'b1; al = a; bl = b;
    it.exp = e; it.due = cyc + NL + 2; it.tag = tag;
    q_l.push_back(it);
  endtask

  task automatic send_s(input logic [162:0] a, input logic [162:0] b, input string tag);
    item_t it;
    @(negedge clk);
    vs = 1'b1; sa = a[MS-1:0]; sb = b[MS-1:0];
    it.exp = gf_ref(a, b, MS, PS); it.due = cyc + NS + 2; it.tag = tag;
    q_s.push_back(it);
  endtask

  // idle cycles with junk on the operand buses (R9)
  task automatic idle(input int n);
    logic [162:0] j;
    repeat (n) begin
      @(negedge clk);
      vl = 1'b0; vs = 1'b0;
      al = rnd(ML); bl = rnd(ML);
      j = rnd(MS); sa = j[MS-1:0];
      j = rnd(MS); sb = j[MS-1:0];
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    item_t it;
    if (ovl) begin
      if (q_l.size() == 0) begin
        chk(1'b0, "R4 unexpected result (main)", pl, '0);
      end else begin
        it = q_l.pop_front();
        chk(pl == it.exp, it.tag, pl, it.exp);
        chk(cyc == it.due, "R2 latency (main)", 163'(cyc), 163'(it.due));
      end
    end
  end

  always @(negedge clk) begin
    item_t it;
    if (ovs) begin
      if (q_s.size() == 0) begin
        chk(1'b0, "R4 unexpected result (small)", 163'(ps), '0);
      end else begin
        it = q_s.pop_front();
        chk(163'(ps) == it.exp, it.tag, 163'(ps), it.exp);
        chk(cyc == it.due, "R2 latency (small)", 163'(cyc), 163'(it.due));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 163'(cyc), '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [162:0] a, b, x162;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; vl = 1'b0; vs = 1'b0;
    al = '0; bl = '0; sa = '0; sb = '0;
    repeat (3) begin
      @(negedge clk);
      chk(ovl == 1'b0 && ovs == 1'b0, "R8 reset state", {161'b0, ovl, ovs}, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R5 identities
    a = rnd(ML); b = rnd(ML);
    send_l(a, 163'd1, a, "R5 a*1");
    send_l(163'd1, b, b, "R5 1*b");
    send_l('0, b, '0, "R5 0*b");
    send_l(a, '0, '0, "R5 a*0");
    idle(2);

    // R6 folding
    x162 = '0; x162[162] = 1'b1;
    send_l(x162, 163'd2, 163'hC9, "R6 x^162*x");
    send_l(x162, x162, gf_ref(x162, x162, ML, PL), "R6 x^162*x^162");
    send_l({163{1'b1}}, {163{1'b1}}, gf_ref({163{1'b1}}, {163{1'b1}}, ML, PL), "R1 all ones");

    // R1/R3 back to back
    for (int i = 0; i < 60; i++) begin
      a = rnd(ML); b = rnd(ML);
      send_l(a, b, gf_ref(a, b, ML, PL), "R3 back-to-back product");
    end
    idle(NL + 5);

    // R9 gapped stream with junk in between
    for (int i = 0; i < 20; i++) begin
      a = rnd(ML); b = rnd(ML);
      send_l(a, b, gf_ref(a, b, ML, PL), "R9 gapped product");
      idle(1 + ($urandom % 3));
    end
    idle(NL + 5);

    // R7 small field, width not a multiple of the digit
    for (int i = 0; i < 40; i++) begin
      send_s(rnd(MS), rnd(MS), "R7 small-field product");
    end
    send_s(163'h1FFF, 163'h1FFF, "R7 all ones");
    send_s(163'h1000, 163'h1000, "R7 x^12*x^12");
    send_s(163'h1, 163'h1234, "R7 one times b");
    idle(NS + 5);

    // R8 reset with products in flight
    for (int i = 0; i < 5; i++) begin
      a = rnd(ML); b = rnd(ML);
      send_l(a, b, gf_ref(a, b, ML, PL), "R8 discarded");
    end
    idle(3);
    @(negedge clk);
    rst_n = 1'b0;
    q_l.delete();
    repeat (3) begin
      @(negedge clk);
      chk(ovl == 1'b0, "R8 valid low in reset", {162'b0, ovl}, '0);
    end
    rst_n = 1'b1;
    idle(NL + 10);
    a = rnd(ML); b = rnd(ML);
    send_l(a, b, gf_ref(a, b, ML, PL), "R8 product after reset");
    idle(NL + 5);

    chk(q_l.size() == 0 && q_s.size() == 0, "R4 every result delivered",
        163'(q_l.size() + q_s.size()), '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule